// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core and owns everything between deciding to take an interrupt and handing the core its new program counter. It watches an edge-triggered non-maskable request, a level-sensitive maskable request and a one-cycle break strobe from the instruction decoder. When it accepts one, it stores the return address and the status byte on the memory stack. It then reads the handler address from a fixed vector at the top of the address space and gives the core a one-cycle load pulse with the new PC, stack pointer and status byte.

The maskable request and the software break share one handler address. The pushed copy of the status byte tells them apart: its break bit is set only for the software case. A one-cycle return strobe makes the block pull the status byte and return address back off the stack, in the reverse order. After reset the block fetches the reset vector by itself. The core keeps the live registers and offers them on `pc_in`, `status_in` and `sp_in` while the sequencer is idle. While `busy` is high, the sequencer owns the byte-wide bus. Memory returns read data one cycle after the address.

Top module: `irq_entry_seq`

## Requirements
- R1: The maskable request (`irq_n` low) is taken only while bit 2 of `status_in` (interrupt-disable) is 0. While that bit is 1 the request has no effect and `busy` stays low. The input is a level: a request held low is taken once the bit clears.
- R2: A falling edge on `nmi_n` is taken whatever the status bits are. An edge that arrives while the block is busy is held and served afterwards. Holding `nmi_n` low produces one entry only.
- R3: When the block is idle and several requests are present, the order of service is non-maskable first, then break, then return, then maskable. Requests that lose and are levels or latched stay pending. A losing break strobe is dropped.
- R4: Entry writes the PC high byte at `0x0100+SP`, then the PC low byte, then the status byte. SP decrements after each write and wraps within page 1. `sp_out` at the load pulse equals `sp_in`-3 modulo 256.
- R5: In the pushed status byte, bit 4 (break) is 1 for a software break and 0 for a maskable or non-maskable entry. All other bits are copied from `status_in`.
- R6: Each vector is read low byte first at the even address, then the high byte at the odd address. The non-maskable vector is at 0xFFFA, reset at 0xFFFC, and maskable/break at 0xFFFE.
- R7: At the entry load pulse, `status_out` is the sampled status with bit 2 set and bit 4 cleared.
- R8: On a return, the block reads the status byte at `0x0100+SP+1`, then the PC low byte, then the PC high byte, incrementing SP before each read. It loads the restored PC, the pulled status with bit 4 cleared, and `sp_in`+3.
- R9: After reset is released, the block reads the reset vector and pulses `pc_load` with that address, `status_out` = 0x04 and `sp_out` = 0xFF. It never writes during or after reset until a request arrives.
- R10: `pc_load` is one cycle wide. It comes 7 clock edges after the deciding edge for an entry, 5 for a return, and 3 after reset release. `busy` is high from the deciding edge up to and including the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, active on falling edge |
| irq_n | input | 1 | Maskable request, active-low level |
| brk_req | input | 1 | One-cycle software break strobe from the decoder |
| rti_req | input | 1 | One-cycle return-from-interrupt strobe from the decoder |
| status_in | input | 8 | Live status byte of the core |
| pc_in | input | 16 | Address to return to |
| sp_in | input | 8 | Live stack pointer |
| rd_data | input | 8 | Read data, valid one cycle after the address |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| status_out | output | 8 | Status byte for the core, valid with `pc_load` |
| sp_out | output | 8 | Stack pointer for the core, valid with `pc_load` |
| pc_out | output | 16 | New program counter, valid with `pc_load` |
| pc_load | output | 1 | One-cycle pulse: core loads PC, SP and status |
| busy | output | 1 | Sequencer owns the bus |

## Verification
A wrong internal stack pointer or sequencing state shows up during the same entry as a stack byte at the wrong address, in the wrong slot or missing. It also changes `sp_out` at the load pulse, at most seven cycles after the request. A lost or sticky non-maskable latch shows up as a missing entry or an extra entry within a few cycles after the block goes idle. A wrong break bit or mask decision shows in the pushed byte or in `busy` rising. Every entry is followed by a return from the same stack, so a corrupted byte also comes back as a wrong PC or status on the return.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants, state and request-kind types for the
// interrupt sequencer. Assumes an 8-bit data bus and a 16-bit address bus.
package irq_seq_pkg;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int I_BIT = 2;
    localparam int B_BIT = 4;
    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [DW-1:0] SP_RESET   = 8'hFF;
    localparam logic [AW-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [AW-1:0] VEC_MASK   = 16'hFFFE;

    typedef enum logic [2:0] {K_RESET, K_NMI, K_BRK, K_IRQ, K_RTI} kind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PUSH_PCH, S_PUSH_PCL, S_PUSH_ST,
        S_VEC_LO, S_VEC_HI, S_VEC_END,
        S_PULL_ST, S_PULL_PCL, S_PULL_PCH, S_PULL_END,
        S_DONE
    } state_t;

    // Map a request kind to the even address of its vector.
    function automatic logic [AW-1:0] vec_base(kind_t k);
        case (k)
            K_NMI:   vec_base = VEC_NMI;
            K_RESET: vec_base = VEC_RST;
            default: vec_base = VEC_MASK;
        endcase
    endfunction
endpackage

// File: rtl/nmi_edge_latch.sv
// Falling-edge detector and hold latch for the non-maskable request.
// The request is visible in the same cycle as the edge, and it stays set
// until the sequencer accepts it (clr). Assumes nmi_n is already synchronous.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic req
);
    logic nmi_q;
    logic pend;
    logic fall;

    assign fall = nmi_q & ~nmi_n;
    assign req  = pend | fall;

    // Keep the previous pin level and hold any unserved edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            pend  <= req & ~clr;
        end
    end

    // R2: an edge that is not accepted at once must still be pending a cycle later
    assert_nmi_edge_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !clr) |=> req);
    // R2: a pending request never disappears unless it was accepted
    assert_nmi_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr) |=> req);
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority choice among the pending requests while the sequencer is idle.
// Order: non-maskable, break, return, maskable (masked by the I flag).
// Assumes the break and return strobes are only one cycle wide.
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  idle,
    input  logic  nmi_req,
    input  logic  brk_req,
    input  logic  rti_req,
    input  logic  irq_req,
    input  logic  i_flag,
    output logic  take,
    output kind_t take_kind,
    output logic  nmi_taken
);
    localparam int NSRC = 4;
    logic [NSRC-1:0] grant;  // {nmi, brk, rti, irq}

    // Priority grant, only one source wins.
    always_comb begin
        grant    = '0;
        grant[3] = idle & nmi_req;
        grant[2] = idle & ~nmi_req & brk_req;
        grant[1] = idle & ~nmi_req & ~brk_req & rti_req;
        grant[0] = idle & ~nmi_req & ~brk_req & ~rti_req & irq_req & ~i_flag;
    end

    // Encode the winning source as a request kind.
    always_comb begin
        take_kind = K_IRQ;
        if (grant[3])      take_kind = K_NMI;
        else if (grant[2]) take_kind = K_BRK;
        else if (grant[1]) take_kind = K_RTI;
    end

    assign take      = |grant;
    assign nmi_taken = grant[3];

    // R3: at most one source is granted in any cycle
    assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R1: a masked maskable request alone never starts a sequence
    assert_irq_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i_flag && !nmi_req && !brk_req && !rti_req) |-> !take);
endmodule

// File: rtl/irq_seq_fsm.sv
// Bus sequencer: pushes the return state and fetches a vector on entry,
// pulls the state back on return, and fetches the reset vector after reset.
// Assumes synchronous memory: rd_data holds the byte addressed one cycle earlier.
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  kind_t         take_kind,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    output logic [DW-1:0] status_out,
    output logic [DW-1:0] sp_out,
    output logic [AW-1:0] pc_out,
    output logic          pc_load,
    output logic          busy
);
    localparam logic [DW-1:0] I_MASK = DW'(1) << I_BIT;
    localparam logic [DW-1:0] B_MASK = DW'(1) << B_BIT;

    state_t        state;
    kind_t         kind_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] st_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] sp_inc;
    logic [DW-1:0] pushed_st;

    assign sp_inc    = sp_q + DW'(1);
    assign pushed_st = (kind_q == K_BRK) ? (st_q | B_MASK) : (st_q & ~B_MASK);

    // State advance and capture of sampled inputs and read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_VEC_LO;
            kind_q <= K_RESET;
            pc_q   <= '0;
            st_q   <= '0;
            sp_q   <= SP_RESET;
            lo_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (take) begin
                    kind_q <= take_kind;
                    pc_q   <= pc_in;
                    st_q   <= status_in;
                    sp_q   <= sp_in;
                    state  <= (take_kind == K_RTI) ? S_PULL_ST : S_PUSH_PCH;
                end
                S_PUSH_PCH: begin sp_q <= sp_q - DW'(1); state <= S_PUSH_PCL; end
                S_PUSH_PCL: begin sp_q <= sp_q - DW'(1); state <= S_PUSH_ST;  end
                S_PUSH_ST:  begin sp_q <= sp_q - DW'(1); state <= S_VEC_LO;   end
                S_VEC_LO:   state <= S_VEC_HI;
                S_VEC_HI:   begin lo_q <= rd_data; state <= S_VEC_END; end
                S_VEC_END:  begin pc_q <= {rd_data, lo_q}; state <= S_DONE; end
                S_PULL_ST:  begin sp_q <= sp_inc; state <= S_PULL_PCL; end
                S_PULL_PCL: begin sp_q <= sp_inc; st_q <= rd_data; state <= S_PULL_PCH; end
                S_PULL_PCH: begin sp_q <= sp_inc; lo_q <= rd_data; state <= S_PULL_END; end
                S_PULL_END: begin pc_q <= {rd_data, lo_q}; state <= S_DONE; end
                default:    state <= S_IDLE;
            endcase
        end
    end

    // Bus address and strobes for the current step.
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        case (state)
            S_PUSH_PCH: begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = pc_q[AW-1:DW]; bus_we = 1'b1; end
            S_PUSH_PCL: begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = pc_q[DW-1:0];  bus_we = 1'b1; end
            S_PUSH_ST:  begin bus_addr = {STACK_PAGE, sp_q}; bus_wdata = pushed_st;     bus_we = 1'b1; end
            S_VEC_LO:   begin bus_addr = vec_base(kind_q);          bus_re = 1'b1; end
            S_VEC_HI:   begin bus_addr = vec_base(kind_q) | AW'(1); bus_re = 1'b1; end
            S_PULL_ST, S_PULL_PCL, S_PULL_PCH: begin
                bus_addr = {STACK_PAGE, sp_inc};
                bus_re   = 1'b1;
            end
            default: ;
        endcase
    end

    // Values handed to the core with the load pulse.
    always_comb begin
        pc_out  = pc_q;
        sp_out  = sp_q;
        pc_load = (state == S_DONE);
        busy    = (state != S_IDLE);
        if (kind_q == K_RTI) status_out = st_q & ~B_MASK;
        else                 status_out = (st_q & ~B_MASK) | I_MASK;
    end

    // R4: every write lands in the stack page
    assert_write_in_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[AW-1:DW] == STACK_PAGE));
    // R4: the stack pointer steps down by one between consecutive pushes
    assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_PCL) |-> (sp_q == $past(sp_q) - DW'(1)));
    // R10: the load pulse is one cycle wide and ends the busy period
    assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> (!pc_load && !busy));
    // R7: after any entry the core restarts with maskable requests blocked
    assert_entry_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && kind_q != K_RTI) |-> status_out[I_BIT]);
    // R6: reads and writes never share a cycle
    assert_no_rw_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
endmodule

// File: rtl/irq_entry_seq.sv
// Top level: edge latch, arbiter and bus sequencer. The core must hold
// pc_in, status_in and sp_in stable while busy is low, and it must load
// pc_out, sp_out and status_out on the pc_load pulse.
module irq_entry_seq
    import irq_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          brk_req,
    input  logic          rti_req,
    input  logic [7:0]    status_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    sp_in,
    input  logic [7:0]    rd_data,
    output logic [15:0]   bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    output logic [7:0]    status_out,
    output logic [7:0]    sp_out,
    output logic [15:0]   pc_out,
    output logic          pc_load,
    output logic          busy
);
    logic  nmi_req;
    logic  nmi_taken;
    logic  take;
    kind_t take_kind;

    nmi_edge_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (nmi_taken),
        .req   (nmi_req)
    );

    irq_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (~busy),
        .nmi_req   (nmi_req),
        .brk_req   (brk_req),
        .rti_req   (rti_req),
        .irq_req   (~irq_n),
        .i_flag    (status_in[I_BIT]),
        .take      (take),
        .take_kind (take_kind),
        .nmi_taken (nmi_taken)
    );

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_kind  (take_kind),
        .pc_in      (pc_in),
        .status_in  (status_in),
        .sp_in      (sp_in),
        .rd_data    (rd_data),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .status_out (status_out),
        .sp_out     (sp_out),
        .pc_out     (pc_out),
        .pc_load    (pc_load),
        .busy       (busy)
    );
endmodule

// File: tb/tb_irq_entry_seq.sv
// Self-checking bench: sweeps entry kinds, return addresses and stack
// positions, and follows every entry with a return. It also covers masking,
// priority, NMI latching and reset. The memory model is a stack page plus fixed vectors.
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1, irq_n = 1'b1, brk_req = 1'b0, rti_req = 1'b0;
    logic [7:0]  status_in = 8'h00, sp_in = 8'hFF, rd_data;
    logic [15:0] pc_in = 16'h0000;
    logic [15:0] bus_addr, pc_out;
    logic [7:0]  bus_wdata, status_out, sp_out;
    logic        bus_we, bus_re, pc_load, busy;

    logic [7:0]  stk [0:255];
    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    localparam logic [15:0] V_NMI = 16'hA1B2, V_RST = 16'hC3D4, V_MSK = 16'hE5F6;

    always #10 clk = ~clk;  // 50 MHz

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .brk_req(brk_req), .rti_req(rti_req), .status_in(status_in),
        .pc_in(pc_in), .sp_in(sp_in), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .status_out(status_out), .sp_out(sp_out),
        .pc_out(pc_out), .pc_load(pc_load), .busy(busy)
    );

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        case (a)
            16'hFFFA: mem_rd = V_NMI[7:0];
            16'hFFFB: mem_rd = V_NMI[15:8];
            16'hFFFC: mem_rd = V_RST[7:0];
            16'hFFFD: mem_rd = V_RST[15:8];
            16'hFFFE: mem_rd = V_MSK[7:0];
            16'hFFFF: mem_rd = V_MSK[15:8];
            default:  mem_rd = (a[15:8] == 8'h01) ? stk[a[7:0]] : 8'hEE;
        endcase
    endfunction

    always @(posedge clk) begin
        if (bus_we && bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;
        rd_data <= mem_rd(bus_addr);
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Count clock edges until the load pulse is seen; note whether busy stayed high.
    task automatic wait_load(output int cyc, output bit busy_ok);
        bit seen = 0;
        cyc = 0; busy_ok = 1;
        while (!seen && cyc < 40) begin
            @(posedge clk); cyc++;
            @(negedge clk); brk_req = 1'b0; rti_req = 1'b0;
            if (!busy) busy_ok = 0;
            if (pc_load) seen = 1;
        end
    endtask

    task automatic idle_for(input string tag, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy || bus_we) bad++;
        end
        chk(tag, 16'(bad), 16'd0);
    endtask

    // k: 0 non-maskable, 1 break, 2 maskable
    task automatic run_entry(input int k, input logic [15:0] pc, input logic [7:0] st,
                             input logic [7:0] sp, input bit hold_nmi);
        int cyc; bit bok;
        logic [7:0] pushed;
        @(negedge clk);
        pc_in = pc; status_in = st; sp_in = sp;
        if (k == 0) nmi_n = 1'b0;
        else if (k == 1) brk_req = 1'b1;
        else irq_n = 1'b0;
        wait_load(cyc, bok);
        pushed = (k == 1) ? (st | 8'h10) : (st & ~8'h10);
        chk("R6 vector", pc_out, (k == 0) ? V_NMI : V_MSK);
        chk("R7 live status", 16'(status_out), 16'((st & ~8'h10) | 8'h04));
        chk("R4 sp after push", 16'(sp_out), 16'(8'(sp - 8'd3)));
        chk("R4 PC high slot", 16'(stk[sp]), 16'(pc[15:8]));
        chk("R4 PC low slot", 16'(stk[8'(sp - 8'd1)]), 16'(pc[7:0]));
        chk("R5 pushed status", 16'(stk[8'(sp - 8'd2)]), 16'(pushed));
        chk("R10 entry latency", 16'(cyc), 16'd7);
        chk("R10 busy held", 16'(bok), 16'd1);
        irq_n = 1'b1;
        if (!hold_nmi) nmi_n = 1'b1;
    endtask

    task automatic run_rti(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp_entry);
        int cyc; bit bok;
        @(negedge clk);
        sp_in = 8'(sp_entry - 8'd3); rti_req = 1'b1;
        wait_load(cyc, bok);
        chk("R8 restored pc", pc_out, pc);
        chk("R8 restored status", 16'(status_out), 16'(st & ~8'h10));
        chk("R8 sp after pull", 16'(sp_out), 16'(sp_entry));
        chk("R10 return latency", 16'(cyc), 16'd5);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc; bit bok;
        logic [15:0] pcs [4];
        logic [7:0]  sps [3];
        pcs[0] = 16'h0000; pcs[1] = 16'h8001; pcs[2] = 16'hFFFF; pcs[3] = 16'h1234;
        sps[0] = 8'hFF; sps[1] = 8'h80; sps[2] = 8'h01;
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;

        // R9: reset state and reset-vector fetch
        repeat (3) @(negedge clk);
        chk("R9 no load in reset", 16'(pc_load), 16'd0);
        chk("R9 no write in reset", 16'(bus_we), 16'd0);
        rst_n = 1'b1;
        wait_load(cyc, bok);
        chk("R9 reset vector", pc_out, V_RST);
        chk("R9 reset status", 16'(status_out), 16'h0004);
        chk("R9 reset sp", 16'(sp_out), 16'h00FF);
        chk("R10 reset latency", 16'(cyc), 16'd3);
        idle_for("R9 idle after reset", 6);

        // Sweep kinds x return addresses x stack positions (wrap at 0x01 for R4)
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 3; s++) begin
                    logic [7:0] st;
                    st = pcs[p][7:0] ^ pcs[p][15:8] ^ sps[s] ^ 8'(k * 37);
                    if (k == 2) st = st & ~8'h04;     // R1: maskable needs I clear
                    else if (k == 0) st = st | 8'h04; // R2: NMI ignores the I flag
                    run_entry(k, pcs[p], st, sps[s], 1'b0);
                    run_rti(pcs[p], st, sps[s]);
                end

        // R1: masked level request is ignored, then taken once the flag clears
        @(negedge clk); status_in = 8'h04; sp_in = 8'hC0; pc_in = 16'h2222; irq_n = 1'b0;
        idle_for("R1 masked irq ignored", 10);
        status_in = 8'h00;
        wait_load(cyc, bok);
        chk("R1 unmasked irq taken", pc_out, V_MSK);
        irq_n = 1'b1;
        idle_for("R1 level released", 4);

        // R2: holding nmi_n low gives a single entry
        run_entry(0, 16'h3333, 8'h00, 8'hB0, 1'b1);
        idle_for("R2 held nmi single entry", 10);
        nmi_n = 1'b1;

        // R3: nmi and break together -> nmi vector, break bit clear
        @(negedge clk); pc_in = 16'h4000; status_in = 8'h00; sp_in = 8'hF0;
        nmi_n = 1'b0; brk_req = 1'b1;
        wait_load(cyc, bok);
        chk("R3 nmi beats brk vector", pc_out, V_NMI);
        chk("R3 nmi beats brk B bit", 16'(stk[8'hEE] & 8'h10), 16'h0000);
        nmi_n = 1'b1;
        idle_for("R3 losing brk dropped", 4);

        // R3: break and maskable together -> break first
        @(negedge clk); pc_in = 16'h5000; status_in = 8'h00; sp_in = 8'hF0;
        irq_n = 1'b0; brk_req = 1'b1;
        wait_load(cyc, bok);
        chk("R3 brk beats irq B bit", 16'(stk[8'hEE] & 8'h10), 16'h0010);
        // R3: return and maskable together -> return first, then maskable
        @(negedge clk); sp_in = 8'hED; rti_req = 1'b1;
        wait_load(cyc, bok);
        chk("R3 rti beats irq pc", pc_out, 16'h5000);
        chk("R3 rti beats irq latency", 16'(cyc), 16'd5);
        sp_in = 8'hF0; pc_in = 16'h5000;
        wait_load(cyc, bok);
        chk("R3 irq follows rti", pc_out, V_MSK);
        chk("R3 irq follows rti sp", 16'(sp_out), 16'h00ED);
        irq_n = 1'b1;

        // R2: an nmi edge during a busy entry is latched and served next
        @(negedge clk); pc_in = 16'h6000; status_in = 8'h00; sp_in = 8'hD0; irq_n = 1'b0;
        @(negedge clk); @(negedge clk); nmi_n = 1'b0;
        @(negedge clk); nmi_n = 1'b1;
        wait_load(cyc, bok);
        chk("R2 busy entry is irq", pc_out, V_MSK);
        irq_n = 1'b1; sp_in = 8'hCD;
        wait_load(cyc, bok);
        chk("R2 latched nmi served", pc_out, V_NMI);
        chk("R2 latched nmi sp", 16'(sp_out), 16'h00CA);
        idle_for("R2 latch cleared", 6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule